// File: doc/BRIEF.md
# Video-mode line packet scheduler

This block decides, packet by packet, what a serial display host sends across one video frame in video mode. It walks the frame line by line through four vertical regions (sync, back porch, active, front porch). On each line it steps through the horizontal parts: the sync-start event, the sync blanking and sync-end event, the back porch blanking, the pixel packet, optional null padding, the front porch blanking, and the end-of-transmission marker. Each packet is offered on a valid/ready port as a descriptor. The descriptor holds an identifier byte, a 16-bit word count and a flag that tells the downstream stage a payload of that many bytes follows.

Checksums, lane striping, the physical layer and the pixel bytes themselves are left to later stages. Timing values and mode bits are plain inputs. The block copies them into its own registers only when a frame begins, so software may rewrite them at any time. While `enable` is high, frames follow one another with no gap. When `enable` drops, the current frame still runs to its end, and then the port goes quiet. The active line count must be at least one.

Top module: `vidpkt_sched`

## Requirements
- R1: `pkt_id[7:6]` carries the virtual channel `vchan` (0 to 3) and `pkt_id[5:0]` carries the data type.
- R2: A line opens with a short event packet. Frame line 0 uses type 0x01. When auto vertical count is off and `vsync_lines` is nonzero, line number `vsync_lines` uses type 0x11. Every other line uses type 0x21.
- R3: A line outside the active region carries nothing after its opening event, except an event of type 0x31 when `sync_end_mode` is 1.
- R4: An active line sends its packets in this order: the opening event, then a blanking packet (type 0x19, long, wc = `hsync_bytes`) followed by event 0x31, then blanking (wc = `hbp_bytes`), then the pixel packet, then null padding, then blanking (wc = `hfp_bytes`). Blanking, null and pixel packets have `pkt_long`=1; events and end-of-transmission have `pkt_long`=0 and wc 0.
- R5: `hsync_skip` removes the sync blanking packet and its 0x31 event from active lines. `hbp_skip` removes the back porch blanking, and `hfp_skip` removes the front porch blanking.
- R6: Pixel packet type and wc depend on `pix_fmt`. Code 0 gives 0x0E with 2 bytes per pixel. Code 1 gives 0x1E with 9/4 bytes per pixel (`hact_pixels` a multiple of 4). Code 2 gives 0x2E with 3 bytes per pixel. Code 3 gives 0x3E with 3 bytes per pixel.
- R7: When `burst_mode` is 0 and `null_bytes` is nonzero, a null packet (type 0x09, wc = `null_bytes`) follows the pixel packet. When `burst_mode` is 1, no null packet is sent.
- R8: Every line ends with an end-of-transmission packet (type 0x08) unless `eot_skip` is 1.
- R9: With `auto_vcount` set, a frame is `vact_lines`+`vfp_lines` lines long and starts with its active lines. Line 0 opens with 0x01, and no 0x11 event is sent.
- R10: While `pkt_valid` is high and `pkt_ready` is low, the descriptor holds steady. Exactly one descriptor is consumed per cycle with both high.
- R11: Inputs are sampled only when a frame starts. A change made during a frame first shows in the next frame.
- R12: After reset, `pkt_valid` is low. With `enable` high, a new frame starts right after the last packet of the previous one. With `enable` low at that point, `pkt_valid` falls and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run frames continuously while high |
| vsync_lines | input | LW | Lines in the vertical sync region |
| vbp_lines | input | LW | Lines in the vertical back porch |
| vact_lines | input | LW | Active lines (at least 1) |
| vfp_lines | input | LW | Lines in the vertical front porch |
| hsync_bytes | input | BW | Word count of the sync blanking packet |
| hbp_bytes | input | BW | Word count of the back porch blanking |
| hfp_bytes | input | BW | Word count of the front porch blanking |
| null_bytes | input | BW | Word count of null padding (0 = none) |
| hact_pixels | input | PW | Active pixels per line |
| pix_fmt | input | 2 | Pixel format code |
| vchan | input | 2 | Virtual channel |
| sync_end_mode | input | 1 | Send 0x31 on non-active lines |
| hsync_skip | input | 1 | Omit sync blanking and its end event |
| hbp_skip | input | 1 | Omit back porch blanking |
| hfp_skip | input | 1 | Omit front porch blanking |
| burst_mode | input | 1 | No null padding |
| auto_vcount | input | 1 | Ignore the vertical sync and back porch counts |
| eot_skip | input | 1 | Omit end-of-transmission packets |
| pkt_valid | output | 1 | Descriptor available |
| pkt_ready | input | 1 | Descriptor taken |
| pkt_id | output | 8 | Channel and data type |
| pkt_wc | output | BW | Word count (0 for short packets) |
| pkt_long | output | 1 | A payload of `pkt_wc` bytes follows |

## Verification
The bench sweeps every combination of the seven mode bits against all four pixel formats. For each frame it rebuilds the packet list arithmetically and compares every descriptor while `pkt_ready` stalls in a pseudo-random pattern. Each corner case below catches a specific kind of bug:
- A design that skipped the wrong region, or left a 0x31 event behind with the sync blanking removed, would show a descriptor out of place.
- Getting the 9/4 packed width wrong would give a wrong pixel word count.
- A zero-line sync region is run to make sure no 0x11 event appears.
- A large sync count is run under auto vertical count; a design that still used it would emit extra blank lines.
- The configuration is changed partway through a frame. A design that sampled early would mix the two frames.
- `enable` is dropped during a frame. A design that stopped too soon, or ran on too long, would be caught at the port.

// File: rtl/vidpkt_pkg.sv
package vidpkt_pkg;

  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_VSE   = 6'h11;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_BLANK = 6'h19;
  localparam logic [5:0] DT_NULL  = 6'h09;
  localparam logic [5:0] DT_EOT   = 6'h08;

  localparam int NSTEP = 8;

  // Order of the enum is the order of packets within a line.
  typedef enum logic [3:0] {
    ST_START    = 4'd0,
    ST_SYNC_BLK = 4'd1,
    ST_SYNC_END = 4'd2,
    ST_BP_BLK   = 4'd3,
    ST_PIX      = 4'd4,
    ST_NULL     = 4'd5,
    ST_FP_BLK   = 4'd6,
    ST_EOT      = 4'd7,
    ST_NONE     = 4'd8
  } step_t;

  typedef struct packed {
    logic hse_mode;
    logic hsa_off;
    logic hbp_off;
    logic hfp_off;
    logic burst;
    logic auto_v;
    logic eot_off;
  } mode_t;

  function automatic logic [7:0] make_id(logic [1:0] vc, logic [5:0] dt);
    return {vc, dt};
  endfunction

  function automatic logic [5:0] pix_dt(logic [1:0] fmt);
    return {fmt, 4'hE};
  endfunction

  function automatic logic [31:0] pix_bytes(logic [31:0] hact, logic [1:0] fmt);
    case (fmt)
      2'd0:    return hact << 1;
      2'd1:    return (hact * 32'd9) >> 2;
      default: return hact * 32'd3;
    endcase
  endfunction

  function automatic logic step_on(step_t s, logic act, mode_t m, logic null_any);
    case (s)
      ST_START:    return 1'b1;
      ST_SYNC_BLK: return act && !m.hsa_off;
      ST_SYNC_END: return act ? !m.hsa_off : m.hse_mode;
      ST_BP_BLK:   return act && !m.hbp_off;
      ST_PIX:      return act;
      ST_NULL:     return act && !m.burst && null_any;
      ST_FP_BLK:   return act && !m.hfp_off;
      ST_EOT:      return !m.eot_off;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vidpkt_vcnt.sv
module vidpkt_vcnt
  import vidpkt_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          line_adv,
  input  logic [LW-1:0] vsa,
  input  logic [LW-1:0] vbp,
  input  logic [LW-1:0] vact,
  input  logic [LW-1:0] vfp,
  input  logic          auto_v,
  output logic          active_line,
  output logic          first_line,
  output logic          vse_line,
  output logic          last_line
);
  localparam int CW = LW + 2;

  logic [CW-1:0] line_q;
  logic [CW-1:0] vs_end, bp_end, act_end, total;
  logic          in_vs, in_bp, in_act, in_fp;

  always_comb begin
    vs_end  = auto_v ? '0 : CW'(vsa);
    bp_end  = vs_end + (auto_v ? '0 : CW'(vbp));
    act_end = bp_end + CW'(vact);
    total   = act_end + CW'(vfp);
    in_vs   = line_q < vs_end;
    in_bp   = (line_q >= vs_end) && (line_q < bp_end);
    in_act  = (line_q >= bp_end) && (line_q < act_end);
    in_fp   = line_q >= act_end;
  end

  assign active_line = in_act;
  assign first_line  = (line_q == '0);
  assign vse_line    = !auto_v && (vsa != '0) && (line_q == CW'(vsa));
  assign last_line   = (line_q == total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line_q <= '0;
    else if (restart)  line_q <= '0;
    else if (line_adv) line_q <= last_line ? '0 : line_q + 1'b1;
  end

  // R2
  line_lt_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (line_q < total));

  // R9
  one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> $onehot({in_vs, in_bp, in_act, in_fp}));

endmodule

// File: rtl/vidpkt_hseq.sv
module vidpkt_hseq
  import vidpkt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  adv,
  input  logic  active_line,
  input  mode_t mode,
  input  logic  null_any,
  output step_t step,
  output logic  line_done
);
  step_t nxt;

  always_comb begin
    nxt = ST_NONE;
    for (int k = NSTEP - 1; k >= 0; k--) begin
      if ((4'(k) > 4'(step)) && step_on(step_t'(4'(k)), active_line, mode, null_any))
        nxt = step_t'(4'(k));
    end
  end

  assign line_done = adv && (nxt == ST_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= ST_START;
    else if (restart) step <= ST_START;
    else if (adv)     step <= line_done ? ST_START : nxt;
  end

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step != ST_NONE);

  // R8
  eot_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && step == ST_EOT) |-> line_done);

endmodule

// File: rtl/vidpkt_sched.sv
module vidpkt_sched
  import vidpkt_pkg::*;
#(
  parameter int LW = 12,
  parameter int BW = 16,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [LW-1:0] vsync_lines,
  input  logic [LW-1:0] vbp_lines,
  input  logic [LW-1:0] vact_lines,
  input  logic [LW-1:0] vfp_lines,
  input  logic [BW-1:0] hsync_bytes,
  input  logic [BW-1:0] hbp_bytes,
  input  logic [BW-1:0] hfp_bytes,
  input  logic [BW-1:0] null_bytes,
  input  logic [PW-1:0] hact_pixels,
  input  logic [1:0]    pix_fmt,
  input  logic [1:0]    vchan,
  input  logic          sync_end_mode,
  input  logic          hsync_skip,
  input  logic          hbp_skip,
  input  logic          hfp_skip,
  input  logic          burst_mode,
  input  logic          auto_vcount,
  input  logic          eot_skip,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [7:0]    pkt_id,
  output logic [BW-1:0] pkt_wc,
  output logic          pkt_long
);
  // Frame-sampled configuration
  logic [LW-1:0] vsa_q, vbp_q, vact_q, vfp_q;
  logic [BW-1:0] hsa_q, hbp_q, hfp_q, null_q, pixwc_q;
  logic [1:0]    fmt_q, vc_q;
  mode_t         mode_q;

  logic  running;
  logic  fire, start_idle, wrap, latch;
  logic  active_line, first_line, vse_line, last_line;
  logic  line_done;
  step_t step;
  logic [5:0] dt;

  assign fire       = pkt_valid && pkt_ready;
  assign start_idle = !running && enable;
  assign wrap       = line_done && last_line;
  assign latch      = start_idle || (wrap && enable);
  assign pkt_valid  = running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
    end else if (start_idle) begin
      running <= 1'b1;
    end else if (wrap && !enable) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsa_q <= '0; vbp_q <= '0; vact_q <= '0; vfp_q <= '0;
      hsa_q <= '0; hbp_q <= '0; hfp_q <= '0; null_q <= '0;
      pixwc_q <= '0; fmt_q <= '0; vc_q <= '0; mode_q <= '0;
    end else if (latch) begin
      vsa_q   <= vsync_lines;
      vbp_q   <= vbp_lines;
      vact_q  <= vact_lines;
      vfp_q   <= vfp_lines;
      hsa_q   <= hsync_bytes;
      hbp_q   <= hbp_bytes;
      hfp_q   <= hfp_bytes;
      null_q  <= null_bytes;
      pixwc_q <= BW'(pix_bytes(32'(hact_pixels), pix_fmt));
      fmt_q   <= pix_fmt;
      vc_q    <= vchan;
      mode_q  <= '{hse_mode: sync_end_mode, hsa_off: hsync_skip,
                   hbp_off: hbp_skip, hfp_off: hfp_skip,
                   burst: burst_mode, auto_v: auto_vcount,
                   eot_off: eot_skip};
    end
  end

  vidpkt_vcnt #(.LW(LW)) u_vcnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (running),
    .restart     (start_idle),
    .line_adv    (line_done),
    .vsa         (vsa_q),
    .vbp         (vbp_q),
    .vact        (vact_q),
    .vfp         (vfp_q),
    .auto_v      (mode_q.auto_v),
    .active_line (active_line),
    .first_line  (first_line),
    .vse_line    (vse_line),
    .last_line   (last_line)
  );

  vidpkt_hseq u_hseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (start_idle),
    .adv         (fire),
    .active_line (active_line),
    .mode        (mode_q),
    .null_any    (null_q != '0),
    .step        (step),
    .line_done   (line_done)
  );

  // Descriptor assembly
  always_comb begin
    dt       = DT_EOT;
    pkt_wc   = '0;
    pkt_long = 1'b0;
    case (step)
      ST_START:    dt = first_line ? DT_VSS : (vse_line ? DT_VSE : DT_HSS);
      ST_SYNC_BLK: begin dt = DT_BLANK; pkt_wc = hsa_q;   pkt_long = 1'b1; end
      ST_SYNC_END: dt = DT_HSE;
      ST_BP_BLK:   begin dt = DT_BLANK; pkt_wc = hbp_q;   pkt_long = 1'b1; end
      ST_PIX:      begin dt = pix_dt(fmt_q); pkt_wc = pixwc_q; pkt_long = 1'b1; end
      ST_NULL:     begin dt = DT_NULL;  pkt_wc = null_q;  pkt_long = 1'b1; end
      ST_FP_BLK:   begin dt = DT_BLANK; pkt_wc = hfp_q;   pkt_long = 1'b1; end
      default:     dt = DT_EOT;
    endcase
    pkt_id = make_id(vc_q, dt);
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_id) && $stable(pkt_wc)));

  // R2
  wrap_vss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wrap && enable) |=> (pkt_valid && pkt_id[5:0] == DT_VSS));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wrap && !enable) |=> !pkt_valid);

  // R4
  long_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_long == ((pkt_id[5:0] == DT_BLANK) ||
                                (pkt_id[5:0] == DT_NULL) ||
                                (pkt_id[3:0] == 4'hE))));

endmodule

// File: tb/sim_vidpkt_sched.sv
`timescale 1ns/1ps
module sim_vidpkt_sched;
  localparam int LW = 12, BW = 16, PW = 12;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          enable = 1'b0;
  logic [LW-1:0] vsync_lines = '0, vbp_lines = '0, vact_lines = 12'd1, vfp_lines = '0;
  logic [BW-1:0] hsync_bytes = '0, hbp_bytes = '0, hfp_bytes = '0, null_bytes = '0;
  logic [PW-1:0] hact_pixels = '0;
  logic [1:0]    pix_fmt = '0, vchan = '0;
  logic sync_end_mode = 0, hsync_skip = 0, hbp_skip = 0, hfp_skip = 0;
  logic burst_mode = 0, auto_vcount = 0, eot_skip = 0;
  logic          pkt_valid, pkt_ready = 1'b0, pkt_long;
  logic [7:0]    pkt_id;
  logic [BW-1:0] pkt_wc;

  vidpkt_sched #(.LW(LW), .BW(BW), .PW(PW)) u0 (.*);

  int checks = 0, errors = 0;
  int e_id [QN];
  int e_wc [QN];
  int e_lg [QN];
  int qn = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic string tag_of(int dt);
    case (dt)
      'h01, 'h11, 'h21: return "R2";
      'h31:             return "R3";
      'h19:             return "R5";
      'h09:             return "R7";
      'h08:             return "R8";
      default:          return "R6";
    endcase
  endfunction

  task automatic push(int dt, int wc, int lg);
    e_id[qn] = {30'(vchan), 6'(dt)} & 'hFF;
    e_wc[qn] = wc;
    e_lg[qn] = lg;
    qn++;
  endtask

  // Build the expected descriptors of one frame from the current inputs.
  task automatic build_frame();
    int vs, vb, total, pw, nxt_act;
    vs = auto_vcount ? 0 : int'(vsync_lines);
    vb = auto_vcount ? 0 : int'(vbp_lines);
    total = vs + vb + int'(vact_lines) + int'(vfp_lines);
    case (pix_fmt)
      2'd0: pw = 2 * int'(hact_pixels);
      2'd1: pw = 2 * int'(hact_pixels) + int'(hact_pixels) / 4;
      default: pw = int'(hact_pixels) + int'(hact_pixels) + int'(hact_pixels);
    endcase
    for (int l = 0; l < total; l++) begin
      nxt_act = (l >= vs + vb && l < vs + vb + int'(vact_lines)) ? 1 : 0;
      if (l == 0) push('h01, 0, 0);
      else if (vs != 0 && l == vs) push('h11, 0, 0);
      else push('h21, 0, 0);
      if (nxt_act == 1) begin
        if (!hsync_skip) begin push('h19, int'(hsync_bytes), 1); push('h31, 0, 0); end
        if (!hbp_skip) push('h19, int'(hbp_bytes), 1);
        push('h0E + 16 * int'(pix_fmt), pw, 1);
        if (!burst_mode && null_bytes != 0) push('h09, int'(null_bytes), 1);
        if (!hfp_skip) push('h19, int'(hfp_bytes), 1);
      end else if (sync_end_mode) begin
        push('h31, 0, 0);
      end
      if (!eot_skip) push('h08, 0, 0);
    end
  endtask

  // Consume descriptors from index 'from' up to qn; drop enable after the
  // descriptor at index 'drop_at' is taken.
  task automatic consume(int from, int upto, int drop_at);
    int p;
    logic held;
    logic [7:0] hid;
    logic [BW-1:0] hwc;
    p = from;
    held = 0;
    while (p < upto) begin
      @(negedge clk);
      if (held) begin
        checks++;
        if (!(pkt_valid && pkt_id == hid && pkt_wc == hwc)) begin
          errors++;
          $display("FAIL R10 held id=%02h wc=%0d exp id=%02h wc=%0d", pkt_id, pkt_wc, hid, hwc);
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pkt_ready = (lfsr[1:0] != 2'b00);
      held = pkt_valid && !pkt_ready;
      hid = pkt_id;
      hwc = pkt_wc;
      if (pkt_valid && pkt_ready) begin
        checks++;
        if (int'(pkt_id) != e_id[p] || int'(pkt_long) != e_lg[p] ||
            int'(pkt_wc) != e_wc[p]) begin
          errors++;
          $display("FAIL R1/%s pkt %0d id=%02h wc=%0d long=%0d exp id=%02h wc=%0d long=%0d",
                   tag_of(e_id[p] & 'h3F), p, pkt_id, pkt_wc, pkt_long,
                   e_id[p], e_wc[p], e_lg[p]);
        end
        if (p == drop_at) enable = 1'b0;
        p++;
      end
    end
    @(negedge clk);
    pkt_ready = 1'b0;
  endtask

  task automatic check_idle(string tag);
    repeat (3) @(negedge clk);
    checks++;
    if (pkt_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s valid=%0b exp 0", tag, pkt_valid);
    end
  endtask

  task automatic run_one();
    qn = 0;
    build_frame();
    @(negedge clk);
    enable = 1'b1;
    consume(0, qn, 0);
    check_idle("R12");
  endtask

  task automatic base_cfg();
    vsync_lines = 12'd2; vbp_lines = 12'd1; vact_lines = 12'd2; vfp_lines = 12'd1;
    hsync_bytes = 16'd4; hbp_bytes = 16'd6; hfp_bytes = 16'd10;
    hact_pixels = 12'd12;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (pkt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset valid=%0b exp 0", pkt_valid);
    end
    rst_n = 1'b1;
    check_idle("R12");

    // Full mode sweep: R3 R4 R5 R6 R7 R8 R9 with R1 channel cycling
    base_cfg();
    for (int m = 0; m < 128; m++) begin
      for (int f = 0; f < 4; f++) begin
        {sync_end_mode, hsync_skip, hbp_skip, hfp_skip, burst_mode, auto_vcount, eot_skip} = 7'(m);
        pix_fmt = 2'(f);
        vchan = 2'(m + f);
        null_bytes = ((m + f) % 3 == 0) ? 16'd0 : 16'd5;
        run_one();
      end
    end

    // R2: no sync region, so no vertical sync-end event
    base_cfg();
    {sync_end_mode, hsync_skip, hbp_skip, hfp_skip, burst_mode, auto_vcount, eot_skip} = 7'b1000000;
    vsync_lines = 12'd0; vbp_lines = 12'd2;
    run_one();

    // R9: large sync and back porch counts ignored under auto vertical count
    base_cfg();
    vsync_lines = 12'd40; vbp_lines = 12'd30; auto_vcount = 1'b1;
    run_one();
    auto_vcount = 1'b0;

    // R11: change mid-frame, old frame must finish unchanged
    base_cfg();
    qn = 0;
    build_frame();
    begin
      int first_n;
      first_n = qn;
      @(negedge clk);
      enable = 1'b1;
      consume(0, 5, -1);
      vact_lines = 12'd3; hfp_bytes = 16'd33; vchan = 2'd2; pix_fmt = 2'd1;
      hsync_skip = 1'b1; vsync_lines = 12'd1;
      build_frame();
      consume(5, first_n, -1);
      consume(first_n, qn, first_n);
      check_idle("R11");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule